// File: doc/BRIEF.md
# Protected Return-Address Stack

This block holds the return addresses of a RISC core in a dedicated hardware stack. It is kept apart from the data stack in memory, so a buffer overrun in local data cannot reach a saved return address. Only two kinds of operation change its contents. A push comes from a call or from an explicit save-link operation. A pop comes from a return, from an explicit restore-link operation, or from a discard operation. Load and store traffic has no port into it.

A return pop produces a one-cycle redirect pulse together with the popped address, which the fetch stage uses as its next PC. A discard pop removes the caller's saved return address and produces no redirect, so the PC is left alone. The stack has a fixed parameterised depth. A push into a full stack raises an overflow exception pulse. A pop from an empty stack raises an underflow exception pulse. A return followed at once by a call (pop and push in the same cycle) overwrites the top entry in place. The stack pointer does not move in that case.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the depth is 0, `empty_o` is 1, `full_o` is 0, `top_o` is 0, and `redirect_o`, `ovf_o`, `udf_o` and `ret_addr_o` are all 0.
- R2: A push alone (`push_i`=1, `pop_i`=0, `drop_i`=0) into a stack that is not full stores `push_addr_i` as the new top and raises the depth by one. This is visible in the cycle after the operation.
- R3: A push alone into a full stack pulses `ovf_o` for one cycle and leaves the depth and the top entry unchanged.
- R4: A return (`pop_i`=1, `drop_i`=0, no push) on a non-empty stack pulses `redirect_o` with `ret_addr_o` equal to the old top. It lowers the depth by one, and `top_o` then shows the entry below.
- R5: A pop or discard with no push on an empty stack pulses `udf_o` and gives no redirect, and the depth stays 0. For a return, `ret_addr_o` becomes 0.
- R6: A discard (`drop_i`=1, alone or together with `pop_i`) removes the top entry and gives no redirect. `ret_addr_o` keeps its previous value.
- R7: A push together with a pop or discard on a non-empty stack replaces the top entry with `push_addr_i` and keeps the depth. It never raises `ovf_o`, even when the stack is full. With `pop_i` alone it also redirects to the old top.
- R8: A push together with a pop or discard on an empty stack pulses `udf_o` and then stores `push_addr_i`, giving depth 1. For a return, `ret_addr_o` becomes 0 and there is no redirect.
- R9: `empty_o` is 1 exactly when the depth is 0. `full_o` is 1 exactly when the depth equals `DEPTH`. `ovf_o` and `udf_o` are never high together.
- R10: Entries come back in last-in, first-out order across the full depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request (call or save-link) |
| push_addr_i | input | XLEN | Return address to push |
| pop_i | input | 1 | Return pop request |
| drop_i | input | 1 | Discard pop request (no jump) |
| top_o | output | XLEN | Current top entry, 0 when empty |
| empty_o | output | 1 | Stack holds no entries |
| full_o | output | 1 | Stack holds DEPTH entries |
| depth_o | output | $clog2(DEPTH+1) | Number of entries held |
| redirect_o | output | 1 | One-cycle pulse: jump to ret_addr_o |
| ret_addr_o | output | XLEN | Address popped by the last return |
| ovf_o | output | 1 | One-cycle overflow exception pulse |
| udf_o | output | 1 | One-cycle underflow exception pulse |

## Verification
Every cycle, the assertions check the local effect of each operation class: depth growth and top update on push, a frozen state on overflow, the return target against the previous top, underflow pulses, no redirect on discard, in-place replacement, and the exclusivity of the two exception pulses. Ordering across many operations can only be shown by the bench's scenarios, which compare against a reference model: last-in, first-out recovery after filling to full depth, `ret_addr_o` holding its value across discards, and the empty-stack push-with-pop case.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_SWAP
  } ras_op_e;
endpackage

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 16,
  parameter int XLEN  = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [XLEN-1:0]  rd_data_o
);
  logic [XLEN-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))   slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int XLEN  = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [XLEN-1:0]  push_addr_i,
  input  logic             pop_i,
  input  logic             drop_i,
  input  logic [XLEN-1:0]  rd_data_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [XLEN-1:0]  wr_data_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             redirect_o,
  output logic [XLEN-1:0]  ret_addr_o,
  output logic             ovf_o,
  output logic             udf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [XLEN-1:0]  ret_q, ret_d;
  logic             redir_q, redir_d, ovf_q, ovf_d, udf_q, udf_d;
  logic             empty, full, is_ret;
  ras_op_e          op;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign is_ret = pop_i & ~drop_i;  // drop wins: no jump

  always_comb begin
    unique case ({push_i, pop_i | drop_i})
      2'b10:   op = OP_PUSH;
      2'b01:   op = OP_POP;
      2'b11:   op = OP_SWAP;
      default: op = OP_IDLE;
    endcase
  end

  assign rd_idx_o  = IDX_W'(cnt_q - CNT_W'(1));
  assign wr_data_o = push_addr_i;

  always_comb begin
    cnt_d    = cnt_q;
    ret_d    = ret_q;
    redir_d  = 1'b0;
    ovf_d    = 1'b0;
    udf_d    = 1'b0;
    wr_en_o  = 1'b0;
    wr_idx_o = IDX_W'(cnt_q);
    unique case (op)
      OP_PUSH: begin
        if (full) ovf_d = 1'b1;
        else begin
          wr_en_o = 1'b1;
          cnt_d   = cnt_q + CNT_W'(1);
        end
      end
      OP_POP: begin
        if (empty) begin
          udf_d = 1'b1;
          if (is_ret) ret_d = '0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
          if (is_ret) begin
            redir_d = 1'b1;
            ret_d   = rd_data_i;
          end
        end
      end
      OP_SWAP: begin
        wr_en_o = 1'b1;
        if (empty) begin
          // pop underflows, push still lands in slot 0
          udf_d    = 1'b1;
          wr_idx_o = '0;
          cnt_d    = CNT_W'(1);
          if (is_ret) ret_d = '0;
        end else begin
          wr_idx_o = rd_idx_o;
          if (is_ret) begin
            redir_d = 1'b1;
            ret_d   = rd_data_i;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ret_q   <= '0;
      redir_q <= 1'b0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ret_q   <= ret_d;
      redir_q <= redir_d;
      ovf_q   <= ovf_d;
      udf_q   <= udf_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign redirect_o = redir_q;
  assign ret_addr_o = ret_q;
  assign ovf_o      = ovf_q;
  assign udf_o      = udf_q;
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int DEPTH = 16,
  parameter int XLEN  = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [XLEN-1:0]  push_addr_i,
  input  logic             pop_i,
  input  logic             drop_i,
  output logic [XLEN-1:0]  top_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] depth_o,
  output logic             redirect_o,
  output logic [XLEN-1:0]  ret_addr_o,
  output logic             ovf_o,
  output logic             udf_o
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [XLEN-1:0]  wr_data, rd_data;
  logic [CNT_W-1:0] cnt;

  ras_ctrl #(.DEPTH(DEPTH), .XLEN(XLEN)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .push_addr_i (push_addr_i),
    .pop_i       (pop_i),
    .drop_i      (drop_i),
    .rd_data_i   (rd_data),
    .rd_idx_o    (rd_idx),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_data_o   (wr_data),
    .cnt_o       (cnt),
    .redirect_o  (redirect_o),
    .ret_addr_o  (ret_addr_o),
    .ovf_o       (ovf_o),
    .udf_o       (udf_o)
  );

  ras_store #(.DEPTH(DEPTH), .XLEN(XLEN)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  assign depth_o = cnt;
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign top_o   = empty_o ? '0 : rd_data;
endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int DEPTH = 16,
  parameter int XLEN  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic [XLEN-1:0]  push_addr_i,
  input logic             pop_i,
  input logic             drop_i,
  input logic [XLEN-1:0]  top_o,
  input logic             empty_o,
  input logic             full_o,
  input logic [CNT_W-1:0] depth_o,
  input logic             redirect_o,
  input logic [XLEN-1:0]  ret_addr_o,
  input logic             ovf_o,
  input logic             udf_o
);
  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && !drop_i && !full_o |=>
      depth_o == $past(depth_o) + CNT_W'(1) && top_o == $past(push_addr_i));

  a_r3_no_overflow_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && !drop_i && full_o |=>
      ovf_o && $stable(depth_o) && $stable(top_o));

  a_r4_return_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !drop_i && !push_i && !empty_o |=>
      redirect_o && ret_addr_o == $past(top_o) && depth_o == $past(depth_o) - CNT_W'(1));

  a_r5_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i || drop_i) && !push_i && empty_o |=> udf_o && !redirect_o && empty_o);

  a_r6_drop_no_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> !redirect_o);

  a_r7_swap_in_place: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && (pop_i || drop_i) && !empty_o |=>
      $stable(depth_o) && top_o == $past(push_addr_i) && !ovf_o);

  a_r9_one_exception: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_o, udf_o}));
endmodule

bind ret_addr_stack ret_addr_stack_chk #(.DEPTH(DEPTH), .XLEN(XLEN)) i_chk (.*);

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;
  localparam int DEPTH = 16;
  localparam int XLEN  = 32;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             push_i = 1'b0, pop_i = 1'b0, drop_i = 1'b0;
  logic [XLEN-1:0]  push_addr_i = '0;
  logic [XLEN-1:0]  top_o, ret_addr_o;
  logic             empty_o, full_o, redirect_o, ovf_o, udf_o;
  logic [CNT_W-1:0] depth_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [XLEN-1:0] m_mem [DEPTH];
  int              m_cnt = 0;
  logic [XLEN-1:0] m_ret = '0;
  bit              m_redir = 0, m_ovf = 0, m_udf = 0;

  always #10 clk = ~clk;  // 50 MHz

  ret_addr_stack #(.DEPTH(DEPTH), .XLEN(XLEN)) i_ret_addr_stack (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .drop_i(drop_i), .top_o(top_o), .empty_o(empty_o),
    .full_o(full_o), .depth_o(depth_o), .redirect_o(redirect_o),
    .ret_addr_o(ret_addr_o), .ovf_o(ovf_o), .udf_o(udf_o)
  );

  task automatic check(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] m_top();
    return (m_cnt == 0) ? '0 : m_mem[m_cnt-1];
  endfunction

  function automatic string op_tag(bit p, bit r, bit d);
    if (p && (r || d)) return (m_cnt == 0) ? "R8" : "R7";
    if (p)             return (m_cnt == DEPTH) ? "R3" : "R2";
    if (r || d)        return (m_cnt == 0) ? "R5" : (d ? "R6" : "R4");
    return "R10";
  endfunction

  task automatic model_step(bit p, logic [XLEN-1:0] a, bit r, bit d);
    bit ret = r && !d;
    m_redir = 0; m_ovf = 0; m_udf = 0;
    if (p && (r || d)) begin
      if (m_cnt == 0) begin
        m_udf = 1; if (ret) m_ret = '0;
        m_mem[0] = a; m_cnt = 1;
      end else begin
        if (ret) begin m_redir = 1; m_ret = m_mem[m_cnt-1]; end
        m_mem[m_cnt-1] = a;
      end
    end else if (p) begin
      if (m_cnt == DEPTH) m_ovf = 1;
      else begin m_mem[m_cnt] = a; m_cnt++; end
    end else if (r || d) begin
      if (m_cnt == 0) begin m_udf = 1; if (ret) m_ret = '0; end
      else begin
        m_cnt--;
        if (ret) begin m_redir = 1; m_ret = m_mem[m_cnt]; end
      end
    end
  endtask

  task automatic check_all(string tag);
    check(tag,  "depth",    XLEN'(depth_o), XLEN'(m_cnt));
    check("R10", "top",     top_o, m_top());
    check("R9", "empty",    XLEN'(empty_o), XLEN'(m_cnt == 0));
    check("R9", "full",     XLEN'(full_o), XLEN'(m_cnt == DEPTH));
    check(tag,  "redirect", XLEN'(redirect_o), XLEN'(m_redir));
    check(tag,  "ret_addr", ret_addr_o, m_ret);
    check(tag,  "ovf",      XLEN'(ovf_o), XLEN'(m_ovf));
    check(tag,  "udf",      XLEN'(udf_o), XLEN'(m_udf));
  endtask

  task automatic op(bit p, logic [XLEN-1:0] a, bit r, bit d);
    string tag;
    @(negedge clk);
    tag = op_tag(p, r, d);
    push_i = p; push_addr_i = a; pop_i = r; drop_i = d;
    model_step(p, a, r, d);
    @(posedge clk);
    #5;
    check_all(tag);
    push_i = 0; pop_i = 0; drop_i = 0;
  endtask

  initial begin
    void'($urandom(32'h1d2c_0a57));
    #35 rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1");
    // R2/R10: fill to full depth
    for (int i = 0; i < DEPTH; i++) op(1, 32'h1000_0000 + 32'(i * 4), 0, 0);
    op(1, 32'hdead_0001, 0, 0);                  // R3 overflow
    op(1, 32'hbeef_0004, 1, 0);                  // R7 swap while full
    for (int i = 0; i < DEPTH; i++) op(0, '0, 1, 0);  // R4/R10 drain
    op(0, '0, 1, 0);                             // R5 return on empty
    op(0, '0, 0, 1);                             // R5 discard on empty
    op(1, 32'h0000_4440, 1, 0);                  // R8 swap on empty
    op(1, 32'h0000_5550, 0, 0);
    op(0, '0, 1, 0);                             // R4 sets ret
    op(0, '0, 0, 1);                             // R6 discard keeps ret
    op(1, 32'h0000_6660, 0, 0);
    op(1, 32'h0000_7770, 0, 1);                  // R7 swap via discard
    op(0, '0, 1, 1);                             // R6 pop+drop acts as discard
    op(0, '0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int unsigned k = $urandom_range(0, 9);
      bit p = (k < 5) || (k == 9);
      bit r = (k >= 5 && k <= 7) || (k == 9 && $urandom_range(0, 1) == 1);
      bit d = (k == 8) || (k == 9 && !r);
      op(p, $urandom(), r, d);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule